// File: doc/BRIEF.md
# DMA Interrupt Status Register Bank

This block is the register front end of a multi-channel DMA controller. Software reaches it over a plain 32-bit register bus that has a byte address, a write enable, write data and combinational read data. The block holds five 32-bit words per channel: source, destination, link pointer, control and configuration. It also holds a global configuration word, a sync word and two raw interrupt vectors, one for terminal count and one for error. The channel engines set bits in these vectors through one-cycle pulse inputs, and software clears them by writing ones.

The per-channel interrupt enables are not written as a separate mask. Each one is taken from an enable bit inside that channel's configuration word. From the masked vectors the block drives a terminal-count interrupt line, an error interrupt line and a line that combines the two. A fixed identification byte sequence sits at the top of the 4 KiB window. Every other location reads as zero, and writes to those locations are dropped.

Top module: `dma_irq_regbank`

## Requirements
- R1: While reset is high the block clears both raw vectors, the global configuration word, the sync word and every channel word. After reset all status reads and all interrupt lines are 0.
- R2: Channel c, word w (0 source, 1 destination, 2 link, 3 control, 4 configuration) sits at byte address 0x100 + 32·c + 4·w. A write there is stored in full and reads back unchanged.
- R3: Bit 15 of channel c's configuration word enables the terminal-count interrupt of channel c, and bit 14 enables its error interrupt. Word 1 (address 0x004) reads raw TC AND TC enables. Word 3 (0x00C) reads raw error AND error enables. Word 0 (0x000) reads the OR of those two words.
- R4: Word 5 (0x014) reads the raw TC vector and word 6 (0x018) reads the raw error vector, whatever the enables are.
- R5: When `tc_set[c]` or `err_set[c]` is high at a rising edge, the matching raw bit is 1 from that edge on and stays 1 until it is cleared.
- R6: Writing word 2 (0x008) clears exactly the raw TC bits written as 1. Writing word 4 (0x010) clears exactly the raw error bits written as 1. All other bits keep their values.
- R7: If a set pulse and a clear write hit the same raw bit in the same cycle, the bit ends up 1.
- R8: `irq_tc` is high when any masked TC bit is 1. `irq_err` is high when any masked error bit is 1. `irq_any` is the OR of the two.
- R9: Word 7 (0x01C) has bit c set exactly when bit 0 of channel c's configuration word is 1.
- R10: Word 12 (0x030) holds the global configuration word and word 13 (0x034) holds the sync word. Both can be written and read back in full.
- R11: Addresses 0xFE0 to 0xFFC return one identification byte each, indexed by (address − 0xFE0)/4. The sequence is 0x80, 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1, and the first byte becomes 0x81 when the block is built with two channels.
- R12: The following locations read as 0, and writes to them change nothing: words 8 to 11, words 14 and 15, any other unlisted address, channel words 5 to 7, channel indices at or beyond the channel count, and any address with bits 1:0 not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wr_data` |
| addr | input | 12 | Byte address within the register window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| tc_set | input | NCH | Per-channel terminal-count set pulses |
| err_set | input | NCH | Per-channel error set pulses |
| irq_tc | output | 1 | Masked terminal-count interrupt level |
| irq_err | output | 1 | Masked error interrupt level |
| irq_any | output | 1 | OR of the two interrupt levels |

## Verification
The bench runs random mixes of channel-word writes, set pulses on random channel subsets and clear writes carrying random bit patterns. This shows whether the clears are bitwise and whether the raw and masked views stay independent of each other. Random configuration words switch the enable bits at positions 15, 14 and 0 on and off, which separates the masked status, the raw status and the enabled-channel readout. Directed cases cover a set pulse colliding with a clear of the same bit, the identification sequence, and the unmapped, misaligned and software-request addresses. For those addresses the bench also writes junk and then reads back the state that the junk could have touched.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
package dma_irq_pkg;

    localparam int DW = 32;
    localparam int AW = 12;

    // Bit positions inside a channel configuration word
    localparam int CFG_ON_BIT     = 0;
    localparam int CFG_ERR_IE_BIT = 14;
    localparam int CFG_TC_IE_BIT  = 15;

    typedef enum logic [3:0] {
        GW_ANY_STAT = 4'd0,
        GW_TC_STAT  = 4'd1,
        GW_TC_CLR   = 4'd2,
        GW_ERR_STAT = 4'd3,
        GW_ERR_CLR  = 4'd4,
        GW_TC_RAW   = 4'd5,
        GW_ERR_RAW  = 4'd6,
        GW_ACTIVE   = 4'd7,
        GW_GCFG     = 4'd12,
        GW_SYNC     = 4'd13
    } gword_e;

    typedef enum logic [2:0] {
        CW_SRC  = 3'd0,
        CW_DST  = 3'd1,
        CW_LINK = 3'd2,
        CW_CTRL = 3'd3,
        CW_CFG  = 3'd4
    } cword_e;

    typedef struct packed {
        logic [DW-1:0] src;
        logic [DW-1:0] dst;
        logic [DW-1:0] link;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] cfg;
    } chan_regs_t;

    typedef struct packed {
        logic       chan;
        logic       glob;
        logic       id;
        logic [2:0] ch;
        cword_e     cw;
        gword_e     gw;
        logic [2:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [AW-1:0] a);
        dec_t d;
        logic aligned;
        aligned = (a[1:0] == 2'b00);
        d.chan  = aligned && (a[11:8] == 4'h1);
        d.glob  = aligned && (a[11:6] == 6'd0);
        d.id    = aligned && (a[11:5] == 7'h7F);
        d.ch    = a[7:5];
        d.cw    = cword_e'(a[4:2]);
        d.gw    = gword_e'(a[5:2]);
        d.idx   = a[4:2];
        return d;
    endfunction

    function automatic logic [7:0] id_byte(input logic [2:0] i, input int nch);
        case (i)
            3'd0:    return (nch == 2) ? 8'h81 : 8'h80;
            3'd1:    return 8'h10;
            3'd2:    return 8'h04;
            3'd3:    return 8'h0A;
            3'd4:    return 8'h0D;
            3'd5:    return 8'hF0;
            3'd6:    return 8'h05;
            default: return 8'hB1;
        endcase
    endfunction

endpackage

// File: rtl/dma_irq_w1c.sv
`timescale 1ns/1ps
// Sticky status vector: per-bit set pulses, write-one-to-clear, set wins.
module dma_irq_w1c #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic         clr_we,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    assign clr_eff = clr_we ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_eff) | set;
    end
endmodule

// File: rtl/dma_irq_chan_bank.sv
`timescale 1ns/1ps
// Per-channel word storage: source, destination, link, control, configuration.
module dma_irq_chan_bank
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   chan_we,
    input  logic [2:0]             ch,
    input  cword_e                 cw,
    input  logic [DW-1:0]          wr_data,
    output chan_regs_t [NCH-1:0]   regs
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        chan_regs_t r;
        logic       hit;

        assign hit     = chan_we && (ch == 3'(c));
        assign regs[c] = r;

        always_ff @(posedge clk) begin
            if (rst) begin
                r <= '0;
            end else if (hit) begin
                case (cw)
                    CW_SRC:  r.src  <= wr_data;
                    CW_DST:  r.dst  <= wr_data;
                    CW_LINK: r.link <= wr_data;
                    CW_CTRL: r.ctrl <= wr_data;
                    CW_CFG:  r.cfg  <= wr_data;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/dma_irq_regbank.sv
`timescale 1ns/1ps
module dma_irq_regbank
    import dma_irq_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [11:0]    addr,
    input  logic [31:0]    wr_data,
    output logic [31:0]    rd_data,
    input  logic [NCH-1:0] tc_set,
    input  logic [NCH-1:0] err_set,
    output logic           irq_tc,
    output logic           irq_err,
    output logic           irq_any
);
    localparam int PADW = DW - NCH;

    dec_t                 dec;
    chan_regs_t [NCH-1:0] regs;
    chan_regs_t           sel;
    logic [NCH-1:0]       raw_tc, raw_err;
    logic [NCH-1:0]       tc_mask, err_mask, active;
    logic [NCH-1:0]       tc_m, err_m;
    logic [DW-1:0]        gcfg_q, sync_q;
    logic                 tc_clr_we, err_clr_we;

    assign dec = decode(addr);

    dma_irq_chan_bank #(.NCH(NCH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .chan_we (wr_en && dec.chan),
        .ch      (dec.ch),
        .cw      (dec.cw),
        .wr_data (wr_data),
        .regs    (regs)
    );

    assign tc_clr_we  = wr_en && dec.glob && (dec.gw == GW_TC_CLR);
    assign err_clr_we = wr_en && dec.glob && (dec.gw == GW_ERR_CLR);

    dma_irq_w1c #(.W(NCH)) u_tc (
        .clk    (clk),
        .rst    (rst),
        .set    (tc_set),
        .clr_we (tc_clr_we),
        .clr    (wr_data[NCH-1:0]),
        .q      (raw_tc)
    );

    dma_irq_w1c #(.W(NCH)) u_err (
        .clk    (clk),
        .rst    (rst),
        .set    (err_set),
        .clr_we (err_clr_we),
        .clr    (wr_data[NCH-1:0]),
        .q      (raw_err)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_mask
        assign tc_mask[c]  = regs[c].cfg[CFG_TC_IE_BIT];
        assign err_mask[c] = regs[c].cfg[CFG_ERR_IE_BIT];
        assign active[c]   = regs[c].cfg[CFG_ON_BIT];
    end

    assign tc_m  = raw_tc  & tc_mask;
    assign err_m = raw_err & err_mask;

    assign irq_tc  = |tc_m;
    assign irq_err = |err_m;
    assign irq_any = irq_tc | irq_err;

    always_ff @(posedge clk) begin
        if (rst) begin
            gcfg_q <= '0;
            sync_q <= '0;
        end else if (wr_en && dec.glob) begin
            if (dec.gw == GW_GCFG) gcfg_q <= wr_data;
            if (dec.gw == GW_SYNC) sync_q <= wr_data;
        end
    end

    // Channel select; an index outside the built channels selects zeros
    always_comb begin
        sel = '0;
        for (int c = 0; c < NCH; c++) begin
            if (dec.ch == 3'(c)) sel = regs[c];
        end
    end

    always_comb begin
        rd_data = '0;
        if (dec.id) begin
            rd_data = {24'd0, id_byte(dec.idx, NCH)};
        end else if (dec.chan) begin
            case (dec.cw)
                CW_SRC:  rd_data = sel.src;
                CW_DST:  rd_data = sel.dst;
                CW_LINK: rd_data = sel.link;
                CW_CTRL: rd_data = sel.ctrl;
                CW_CFG:  rd_data = sel.cfg;
                default: rd_data = '0;
            endcase
        end else if (dec.glob) begin
            case (dec.gw)
                GW_ANY_STAT: rd_data = {{PADW{1'b0}}, tc_m | err_m};
                GW_TC_STAT:  rd_data = {{PADW{1'b0}}, tc_m};
                GW_ERR_STAT: rd_data = {{PADW{1'b0}}, err_m};
                GW_TC_RAW:   rd_data = {{PADW{1'b0}}, raw_tc};
                GW_ERR_RAW:  rd_data = {{PADW{1'b0}}, raw_err};
                GW_ACTIVE:   rd_data = {{PADW{1'b0}}, active};
                GW_GCFG:     rd_data = gcfg_q;
                GW_SYNC:     rd_data = sync_q;
                default:     rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dma_irq_regbank_chk.sv
`timescale 1ns/1ps
module dma_irq_regbank_chk #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           wr_en,
    input logic [11:0]    addr,
    input logic [31:0]    wr_data,
    input logic [NCH-1:0] tc_set,
    input logic [NCH-1:0] err_set,
    input logic [NCH-1:0] raw_tc,
    input logic [NCH-1:0] raw_err,
    input logic [NCH-1:0] tc_mask,
    input logic [NCH-1:0] err_mask,
    input logic           irq_tc,
    input logic           irq_err,
    input logic           irq_any
);
    logic rst_d;

    always_ff @(posedge clk) rst_d <= rst;

    // R1: one cycle after reset was high, status and lines are clear
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_clears: assert (raw_tc == '0 && raw_err == '0 && !irq_any)
                else $error("a_r1_reset_clears");
        end
    end

    // R5 and R7: a set pulse always lands, even against a clear
    a_r5_r7_tc_set_lands: assert property (@(posedge clk) disable iff (rst)
        (tc_set != '0) |=> ((raw_tc & $past(tc_set)) == $past(tc_set)));

    a_r5_r7_err_set_lands: assert property (@(posedge clk) disable iff (rst)
        (err_set != '0) |=> ((raw_err & $past(err_set)) == $past(err_set)));

    // R5: raw bits rise only through a set pulse
    a_r5_tc_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (tc_set == '0) |=> ((raw_tc & ~$past(raw_tc)) == '0));

    a_r5_err_no_spurious: assert property (@(posedge clk) disable iff (rst)
        (err_set == '0) |=> ((raw_err & ~$past(raw_err)) == '0));

    // R6: a clear write without a colliding set removes the written ones
    a_r6_tc_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'h008 && tc_set == '0)
            |=> ((raw_tc & $past(wr_data[NCH-1:0])) == '0));

    a_r6_err_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 12'h010 && err_set == '0)
            |=> ((raw_err & $past(wr_data[NCH-1:0])) == '0));

    // R8: interrupt lines against raw state and channel enables
    a_r8_tc_line: assert property (@(posedge clk) disable iff (rst)
        irq_tc == ((raw_tc & tc_mask) != '0));

    a_r8_err_line: assert property (@(posedge clk) disable iff (rst)
        irq_err == ((raw_err & err_mask) != '0));

    a_r8_any_line: assert property (@(posedge clk) disable iff (rst)
        irq_any == (irq_tc || irq_err));
endmodule

bind dma_irq_regbank dma_irq_regbank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .tc_set   (tc_set),
    .err_set  (err_set),
    .raw_tc   (raw_tc),
    .raw_err  (raw_err),
    .tc_mask  (tc_mask),
    .err_mask (err_mask),
    .irq_tc   (irq_tc),
    .irq_err  (irq_err),
    .irq_any  (irq_any)
);

// File: tb/dma_irq_regbank_test.sv
`timescale 1ns/1ps
module dma_irq_regbank_test;
    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           wr_en = 1'b0;
    logic [11:0]    addr = '0;
    logic [31:0]    wr_data = '0;
    logic [31:0]    rd_data;
    logic [NCH-1:0] tc_set = '0;
    logic [NCH-1:0] err_set = '0;
    logic           irq_tc, irq_err, irq_any;

    always #2.5 clk = ~clk;

    dma_irq_regbank #(.NCH(NCH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .tc_set(tc_set), .err_set(err_set),
        .irq_tc(irq_tc), .irq_err(irq_err), .irq_any(irq_any)
    );

    // Reference state built from the requirements
    logic [31:0]    m_ch [NCH][5];
    logic [NCH-1:0] m_tc, m_err;
    logic [31:0]    m_gcfg, m_sync;
    int n_tests = 0;
    int n_fail  = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NCH-1:0] m_tcmask();
        logic [NCH-1:0] m;
        for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][15];
        return m;
    endfunction

    function automatic logic [NCH-1:0] m_errmask();
        logic [NCH-1:0] m;
        for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][14];
        return m;
    endfunction

    function automatic logic [NCH-1:0] m_active();
        logic [NCH-1:0] m;
        for (int c = 0; c < NCH; c++) m[c] = m_ch[c][4][0];
        return m;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [11:0] a);
        logic [7:0] ids [8];
        ids = '{8'h80, 8'h10, 8'h04, 8'h0A, 8'h0D, 8'hF0, 8'h05, 8'hB1};
        if (a[1:0] != 2'b00) return 32'd0;
        if (a >= 12'hFE0) return {24'd0, ids[a[4:2]]};
        if (a[11:8] == 4'h1) begin
            if (int'(a[7:5]) < NCH && a[4:2] < 3'd5) return m_ch[a[7:5]][a[4:2]];
            return 32'd0;
        end
        if (a[11:6] != 6'd0) return 32'd0;
        case (a[5:2])
            4'd0:  return 32'((m_tc & m_tcmask()) | (m_err & m_errmask()));
            4'd1:  return 32'(m_tc & m_tcmask());
            4'd3:  return 32'(m_err & m_errmask());
            4'd5:  return 32'(m_tc);
            4'd6:  return 32'(m_err);
            4'd7:  return 32'(m_active());
            4'd12: return m_gcfg;
            4'd13: return m_sync;
            default: return 32'd0;
        endcase
    endfunction

    function automatic void model_reset();
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++) m_ch[c][w] = '0;
        m_tc = '0; m_err = '0; m_gcfg = '0; m_sync = '0;
    endfunction

    // One bus cycle with optional write and set pulses; model updates at the edge
    task automatic cycle(input logic we, input logic [11:0] a, input logic [31:0] d,
                         input logic [NCH-1:0] ts, input logic [NCH-1:0] es);
        logic [NCH-1:0] ct, ce;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; tc_set = ts; err_set = es;
        @(posedge clk);
        ct = (we && a == 12'h008) ? d[NCH-1:0] : '0;
        ce = (we && a == 12'h010) ? d[NCH-1:0] : '0;
        if (we && a[1:0] == 2'b00) begin
            if (a[11:8] == 4'h1 && int'(a[7:5]) < NCH && a[4:2] < 3'd5)
                m_ch[a[7:5]][a[4:2]] = d;
            else if (a == 12'h030) m_gcfg = d;
            else if (a == 12'h034) m_sync = d;
        end
        m_tc  = (m_tc & ~ct) | ts;
        m_err = (m_err & ~ce) | es;
        #1;
        wr_en = 1'b0; tc_set = '0; err_set = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cycle(1'b1, a, d, '0, '0);
    endtask

    task automatic rd_check(input string req, input logic [11:0] a);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1;
        check(req, rd_data, exp_rd(a));
    endtask

    task automatic irq_check(input string req);
        logic t, e;
        @(negedge clk);
        t = |(m_tc & m_tcmask());
        e = |(m_err & m_errmask());
        check(req, {29'd0, irq_any, irq_err, irq_tc}, {29'd0, t | e, e, t});
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        foreach (m_tc[i]) ;
        for (int a = 0; a < 16; a++) rd_check("R1 reset global", 12'(a * 4));
        rd_check("R1 reset ch0 cfg", 12'h110);
        rd_check("R1 reset ch7 src", 12'h1E0);
        irq_check("R1 reset irq lines");

        // R2: channel words read back
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++)
                wr(12'(12'h100 + c * 32 + w * 4), 32'hA000_0000 | 32'(c * 16 + w));
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 5; w++)
                rd_check("R2 channel word", 12'(12'h100 + c * 32 + w * 4));
        for (int c = 0; c < NCH; c++) wr(12'(12'h110 + c * 32), 32'd0);

        // R4, R5: raw bits set with all enables off, no interrupt
        cycle(1'b0, 12'h000, 32'd0, 8'hA5, 8'h3C);
        rd_check("R4 R5 raw tc", 12'h014);
        rd_check("R4 R5 raw err", 12'h018);
        rd_check("R3 masked tc with enables off", 12'h004);
        irq_check("R8 lines low with enables off");

        // R3, R8, R9: enables from configuration bits
        wr(12'h110, 32'h0000_8001);   // ch0: tc enable, on
        wr(12'h150, 32'h0000_4000);   // ch2: err enable
        wr(12'h170, 32'h0000_C001);   // ch3: both, on
        rd_check("R3 masked tc", 12'h004);
        rd_check("R3 masked err", 12'h00C);
        rd_check("R3 combined status", 12'h000);
        rd_check("R9 enabled channels", 12'h01C);
        irq_check("R8 lines with enables");

        // R6: exact bitwise clear
        wr(12'h008, 32'h0000_0021);
        rd_check("R6 tc clear bits", 12'h014);
        wr(12'h010, 32'h0000_0004);
        rd_check("R6 err clear bits", 12'h018);
        irq_check("R8 after clears");

        // R7: set collides with clear of same bit
        cycle(1'b1, 12'h008, 32'h0000_00FF, 8'h01, 8'h00);
        rd_check("R7 set wins over tc clear", 12'h014);
        cycle(1'b1, 12'h010, 32'h0000_00FF, 8'h00, 8'h08);
        rd_check("R7 set wins over err clear", 12'h018);

        // R10: global config and sync
        wr(12'h030, 32'hDEAD_BEEF);
        wr(12'h034, 32'h1234_5678);
        rd_check("R10 global config", 12'h030);
        rd_check("R10 sync", 12'h034);

        // R11: identification bytes
        for (int i = 0; i < 8; i++) rd_check("R11 id byte", 12'(12'hFE0 + i * 4));

        // R12: unmapped reads, and writes that change nothing
        for (int i = 8; i < 12; i++) rd_check("R12 sw request word", 12'(i * 4));
        rd_check("R12 word 14", 12'h038);
        rd_check("R12 gap", 12'h040);
        rd_check("R12 channel word 5", 12'h114);
        rd_check("R12 misaligned", 12'h102);
        rd_check("R12 beyond channels", 12'h200);
        wr(12'h114, 32'hFFFF_FFFF);
        wr(12'h11C, 32'hFFFF_FFFF);
        wr(12'h101, 32'hFFFF_FFFF);
        wr(12'h009, 32'hFFFF_FFFF);
        wr(12'h020, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        for (int w = 0; w < 8; w++) rd_check("R12 ch0 untouched", 12'(12'h100 + w * 4));
        rd_check("R12 raw tc untouched", 12'h014);
        rd_check("R12 global config untouched", 12'h030);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            logic [11:0] a;
            op = int'($urandom % 5);
            case (op)
                0: cycle(1'b1, {4'h1, 3'($urandom), 3'($urandom % 5), 2'b00}, $urandom,
                         '0, '0);
                1: cycle(1'b0, 12'h000, 32'd0, NCH'($urandom), NCH'($urandom));
                2: cycle(1'b1, ($urandom % 2) ? 12'h008 : 12'h010, $urandom,
                         NCH'($urandom), NCH'($urandom));
                3: cycle(1'b1, {6'd0, 4'($urandom), 2'b00}, $urandom, '0, '0);
                default: begin
                    case ($urandom % 4)
                        0: a = {6'd0, 4'($urandom), 2'b00};
                        1: a = {4'h1, 3'($urandom), 3'($urandom), 2'b00};
                        2: a = {7'h7F, 3'($urandom), 2'b00};
                        default: a = 12'($urandom);
                    endcase
                    rd_check("R2 R3 R4 R9 R12 random read", a);
                    irq_check("R5 R6 R8 random lines");
                end
            endcase
        end
        rd_check("R6 R7 final raw tc", 12'h014);
        rd_check("R6 R7 final raw err", 12'h018);

        // R1: reset again after activity
        @(negedge clk); rst = 1'b1;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 1'b0;
        rd_check("R1 reset raw tc", 12'h014);
        rd_check("R1 reset sync", 12'h034);
        rd_check("R1 reset ch3 cfg", 12'h170);
        irq_check("R1 reset lines");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule